// File: doc/BRIEF.md
# Many-Time-Programmable Byte Memory with Mode Control

This block is a synthesizable model of a byte-wide nonvolatile memory together with the logic that picks its operating mode. The pins it sees are an active-low chip select, an active-low output gate and an active-low program strobe. It also has an address bus, an 8-bit data input, an 8-bit data output and an output-drive flag. Two single-bit inputs take the place of the two high-voltage conditions: one for the programming supply and one for the raised level on address line 9. From these the block decodes one of these modes:

- read
- output off
- standby
- byte program
- chip erase
- write inhibit
- identification

The stored array is kept in registers and changes on the system clock. A program operation can only clear bits: the new content is the old byte ANDed with the input byte. Bits go back to 1 only through a chip erase, which sets every byte to FFh.

The strobe is sampled on the clock and edge-detected. Each low-going assertion therefore performs exactly one program or erase, however long it is held.

`ADDR_W` sets the depth of the modelled array. `ID_AW` sets the nominal address width that selects the density code returned in identification mode.

Top module: `mtp_mem_ctrl`

## Requirements
- R1: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0 and `hv_pp`=0. In read mode (`hv_a9`=0 as well), `dq_out` equals the stored byte at `addr`.
- R2: `dq_oe` is 0 whenever `ce_n` or `oe_n` is 1.
- R3: With `hv_pp`=1, `hv_a9`=0, `ce_n`=0 and `oe_n`=1, a falling edge of `pgm_n` (sampled on the clock) updates the byte at `addr` using `dq_in`.
- R4: A program stores the old byte AND `dq_in`. No program can change a stored 0 into 1.
- R5: With `hv_pp`=1, `hv_a9`=1, `ce_n`=0 and `oe_n`=1, a falling edge of `pgm_n` sets every byte to FFh. The values of `addr` and `dq_in` have no effect.
- R6: With `ce_n`=1, no strobe edge programs or erases anything, whatever the high-voltage flags are.
- R7: Identification mode is `hv_a9`=1, `hv_pp`=0, `ce_n`=0 and `oe_n`=0. With `addr[ADDR_W-1:1]`=0 and `addr[0]`=0, `dq_out` is BFh.
- R8: In identification mode with `addr`=1, `dq_out` is the density code:
  - A3h for `ID_AW`<=15
  - A4h for 16
  - A5h for 17
  - A6h for `ID_AW`>=18
- R9: One strobe assertion performs at most one operation. While `pgm_n` stays low, a later change of `dq_in` does not alter the array.
- R10: After synchronous reset (`rst_n`=0 at a clock edge) every byte reads FFh.
- R11: In identification mode, any address with a nonzero bit above bit 0 reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program/erase strobe, active low |
| hv_pp | input | 1 | Programming high voltage present |
| hv_a9 | input | 1 | High voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data to program |
| dq_out | output | 8 | Read or identification data (00h when not driven) |
| dq_oe | output | 1 | Data output drive enable |

## Verification
Programming is tried with three patterns:
- A first write into an erased byte, which tells an AND from a plain overwrite only in later steps.
- A second write with a partly overlapping mask.
- A write of all ones, which separates AND behaviour from OR or replace behaviour.

The held-strobe pattern changes the input byte mid-assertion, so a level-triggered write would show up as a different result. Inhibit pulses under both high-voltage combinations must leave known bytes unchanged. Identification reads cover both codes, two off-table addresses and three extra density settings, and an erase with zero data at an arbitrary address must restore FFh everywhere.

// File: rtl/mtp_pkg.sv
// Shared mode encoding and identification codes for the MTP byte memory.
// Assumes callers pass the nominal address width when asking for a code.
package mtp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUT_OFF,
        MD_READ,
        MD_IDENT,
        MD_PROGRAM,
        MD_ERASE,
        MD_INHIBIT,
        MD_ILLEGAL
    } mtp_mode_e;

    localparam logic [7:0] MFR_CODE = 8'hBF;

    // Density code chosen by the nominal address width.
    function automatic logic [7:0] dev_code(input int aw);
        if (aw <= 15)      return 8'hA3;
        else if (aw == 16) return 8'hA4;
        else if (aw == 17) return 8'hA5;
        else               return 8'hA6;
    endfunction

endpackage

// File: rtl/mtp_mode_decode.sv
// Decodes the control pins and high-voltage flags into one operating mode.
// Assumes the inputs are stable levels; purely combinational.
module mtp_mode_decode
    import mtp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      hv_pp,
    input  logic      hv_a9,
    output mtp_mode_e mode
);

    // Priority: deselect first, then high-voltage modes, then read-side modes.
    always_comb begin
        if (ce_n) begin
            mode = hv_pp ? MD_INHIBIT : MD_STANDBY;
        end else if (hv_pp) begin
            if (oe_n) mode = hv_a9 ? MD_ERASE : MD_PROGRAM;
            else      mode = MD_ILLEGAL;
        end else if (oe_n) begin
            mode = MD_OUT_OFF;
        end else begin
            mode = hv_a9 ? MD_IDENT : MD_READ;
        end
    end

endmodule

// File: rtl/mtp_strobe_edge.sv
// Turns the active-low strobe into a one-cycle pulse on its falling edge.
// Assumes the strobe is already synchronous to clk.
module mtp_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);

    logic strobe_q;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_n;
    end

    assign fall = strobe_q & ~strobe_n;

    AST_ONE_EVENT_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R9

endmodule

// File: rtl/mtp_array.sv
// Register-based byte array: program ANDs into one byte, erase sets all to FFh.
// Assumes prog_en and erase_en are single-cycle requests; erase wins.
module mtp_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          erase_en,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Reset or erase to FFh, otherwise clear-only byte programming.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (prog_en) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];

    AST_PROG_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !erase_en) |=> ((mem[$past(waddr)] & ~$past(mem[waddr])) == 8'h00)); // R4
    AST_ERASE_FILLS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF)); // R5

endmodule

// File: rtl/mtp_mem_ctrl.sv
// Top of the MTP byte memory: mode decode, strobe edge detect, array, output mux.
// Assumes all inputs are synchronous to clk and ADDR_W >= 2.
module mtp_mem_ctrl
    import mtp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ID_AW  = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              hv_pp,
    input  logic              hv_a9,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);

    localparam logic [7:0] DEV_ID = dev_code(ID_AW);

    mtp_mode_e  mode;
    logic       fall;
    logic       prog_en;
    logic       erase_en;
    logic [7:0] rdata;
    logic       id_upper_zero;

    mtp_mode_decode u_dec (
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .hv_pp (hv_pp),
        .hv_a9 (hv_a9),
        .mode  (mode)
    );

    mtp_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (pgm_n),
        .fall     (fall)
    );

    // A strobe edge acts only in the matching high-voltage mode.
    always_comb begin
        prog_en  = fall && (mode == MD_PROGRAM);
        erase_en = fall && (mode == MD_ERASE);
    end

    mtp_array #(.AW(ADDR_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .waddr    (addr),
        .wdata    (dq_in),
        .raddr    (addr),
        .rdata    (rdata)
    );

    assign id_upper_zero = (addr[ADDR_W-1:1] == '0);

    // Select array data or identification code and the drive flag.
    always_comb begin
        dq_oe  = 1'b0;
        dq_out = 8'h00;
        case (mode)
            MD_READ: begin
                dq_oe  = 1'b1;
                dq_out = rdata;
            end
            MD_IDENT: begin
                dq_oe = 1'b1;
                if (id_upper_zero) dq_out = addr[0] ? DEV_ID : MFR_CODE;
            end
            default: ;
        endcase
    end

    AST_HIZ_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> !dq_oe); // R2
    AST_NO_DRIVE_UNDER_HV: assert property (@(posedge clk) disable iff (!rst_n)
        hv_pp |-> !dq_oe); // R1
    AST_INHIBIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!prog_en && !erase_en)); // R6
    AST_IDENT_OFFTABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !hv_pp && hv_a9 && addr[ADDR_W-1:1] != '0) |-> (dq_out == 8'h00)); // R11

endmodule

// File: tb/mtp_mem_ctrl_tb.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module mtp_mem_ctrl_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic          hv_pp = 1'b0, hv_a9 = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = 8'h00;
    logic [7:0]    dq_out, out16, out17, out18;
    logic          dq_oe, oe16, oe17, oe18;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mtp_mem_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .hv_pp(hv_pp), .hv_a9(hv_a9), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe));

    mtp_mem_ctrl #(.ADDR_W(4), .ID_AW(16)) u_id16 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .hv_pp(hv_pp), .hv_a9(hv_a9), .addr(addr[3:0]), .dq_in(dq_in),
        .dq_out(out16), .dq_oe(oe16));
    mtp_mem_ctrl #(.ADDR_W(4), .ID_AW(17)) u_id17 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .hv_pp(hv_pp), .hv_a9(hv_a9), .addr(addr[3:0]), .dq_in(dq_in),
        .dq_out(out17), .dq_oe(oe17));
    mtp_mem_ctrl #(.ADDR_W(4), .ID_AW(18)) u_id18 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .hv_pp(hv_pp), .hv_a9(hv_a9), .addr(addr[3:0]), .dq_in(dq_in),
        .dq_out(out18), .dq_oe(oe18));

    // Reference model state.
    logic [7:0] ref_mem [256];
    bit         ref_q;
    logic       e_oe;
    logic [7:0] e_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
            ref_q = 1'b1;
        end else begin
            if (ref_q && !pgm_n && !ce_n && hv_pp && oe_n) begin
                if (hv_a9) begin
                    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
                end else begin
                    ref_mem[addr] = ref_mem[addr] & dq_in;
                end
            end
            ref_q = pgm_n;
        end
    end

    // Per-cycle comparison, 2 ns before the next rising edge.
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            e_oe = !ce_n && !oe_n && !hv_pp;
            checks++;
            if (dq_oe !== e_oe) begin
                failures++;
                $display("FAIL R2 per-cycle dq_oe act=%b exp=%b", dq_oe, e_oe);
            end
            if (e_oe) begin
                if (hv_a9) e_d = (addr[AW-1:1] == 0) ? (addr[0] ? 8'hA3 : 8'hBF) : 8'h00;
                else       e_d = ref_mem[addr];
                checks++;
                if (dq_out !== e_d) begin
                    failures++;
                    $display("FAIL R1 per-cycle dq_out act=%h exp=%h", dq_out, e_d);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; hv_pp = 1'b0; pgm_n = 1'b1; addr = a;
        #3;
        d = dq_out; oe = dq_oe;
    endtask

    task automatic pulse(input logic ce, input logic a9, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = ce; oe_n = 1'b1; hv_pp = 1'b1; hv_a9 = a9; addr = a; dq_in = d; pgm_n = 1'b1;
        @(negedge clk); pgm_n = 1'b0;
        @(negedge clk); pgm_n = 1'b1;
        @(negedge clk); hv_pp = 1'b0; hv_a9 = 1'b0; ce_n = 1'b1;
    endtask

    initial begin
        logic [7:0] d;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: erased after reset
        rd(8'h00, d, oe); chk("R1 drive in read", {7'd0, oe}, 8'd1); chk("R10 addr 00", d, 8'hFF);
        rd(8'h55, d, oe); chk("R10 addr 55", d, 8'hFF);
        rd(8'hFF, d, oe); chk("R10 addr FF", d, 8'hFF);

        // R2: gated output
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #3; chk("R2 ce_n high", {7'd0, dq_oe}, 8'd0);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #3; chk("R2 oe_n high", {7'd0, dq_oe}, 8'd0);

        // R3 / R4: programming clears only
        pulse(1'b0, 1'b0, 8'h10, 8'h3C); rd(8'h10, d, oe); chk("R3 first program", d, 8'h3C);
        pulse(1'b0, 1'b0, 8'h10, 8'hF0); rd(8'h10, d, oe); chk("R4 AND program", d, 8'h30);
        pulse(1'b0, 1'b0, 8'h10, 8'hFF); rd(8'h10, d, oe); chk("R4 no bit set", d, 8'h30);

        // R9: held strobe performs one write only
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; hv_pp = 1'b1; addr = 8'h20; dq_in = 8'hF0;
        @(negedge clk); pgm_n = 1'b0;
        repeat (2) @(negedge clk); dq_in = 8'h0F;
        repeat (2) @(negedge clk); pgm_n = 1'b1;
        // R1: no drive under programming voltage even with oe_n low
        @(negedge clk); oe_n = 1'b0; #3; chk("R1 hv_pp blocks drive", {7'd0, dq_oe}, 8'd0);
        rd(8'h20, d, oe); chk("R9 single write per strobe", d, 8'hF0);

        // R6: inhibit for program and erase
        pulse(1'b1, 1'b0, 8'h10, 8'h00); rd(8'h10, d, oe); chk("R6 inhibit program", d, 8'h30);
        pulse(1'b1, 1'b1, 8'h10, 8'h00); rd(8'h20, d, oe); chk("R6 inhibit erase", d, 8'hF0);

        // R7 / R8 / R11: identification
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; hv_pp = 1'b0; hv_a9 = 1'b1; addr = 8'h00;
        #3; chk("R7 manufacturer code", dq_out, 8'hBF);
        @(negedge clk); addr = 8'h01; #3;
        chk("R8 code ID_AW=8", dq_out, 8'hA3);
        chk("R8 code ID_AW=16", out16, 8'hA4);
        chk("R8 code ID_AW=17", out17, 8'hA5);
        chk("R8 code ID_AW=18", out18, 8'hA6);
        @(negedge clk); addr = 8'h02; #3; chk("R11 off-table 02", dq_out, 8'h00);
        @(negedge clk); addr = 8'h81; #3; chk("R11 off-table 81", dq_out, 8'h00);
        @(negedge clk); hv_a9 = 1'b0;

        // R5: chip erase ignores address and data
        pulse(1'b0, 1'b1, 8'h77, 8'h00);
        rd(8'h10, d, oe); chk("R5 erase addr 10", d, 8'hFF);
        rd(8'h20, d, oe); chk("R5 erase addr 20", d, 8'hFF);
        rd(8'h77, d, oe); chk("R5 erase addr 77", d, 8'hFF);

        repeat (2) @(negedge clk);
        done = 1;
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule